// File: doc/BRIEF.md
# Chip-Select Framed Serial Byte Receiver

This block receives command and data bytes on a write-only two-wire serial link made of a data line and a serial clock. The link is gated by two chip-select inputs, one active low and one active high. The link is live only while both are asserted. All link inputs are first synchronized into the system clock. Serial clock rising edges are found in the system clock domain. Each rising edge shifts one bit into a byte-wide shift register, most significant bit first.

The last rising edge of each byte completes it. On that same edge the data/command select input is sampled to tag the byte. The tag is high for display data and low for a command. The completed byte and its tag go out together with a one-system-clock strobe, ready for the command decoder and the RAM write logic. A deselect at any time clears the shift register and the bit counter, so a partly received byte is dropped.

The output is a valid-only stream with no back-pressure. The consumer must take the byte in the cycle the strobe is high. The byte and tag outputs hold their values until the next strobe.

Top module: `serial_byte_rx`

## Requirements
- R1: After reset, `byte_vld`, `byte_data` and `byte_is_data` are all 0.
- R2: Bits are assembled most significant bit first: the first rising edge of a byte supplies `byte_data[7]` and the eighth supplies `byte_data[0]`.
- R3: Each eighth accepted rising edge of `sclk` produces exactly one `byte_vld` pulse, one system clock wide.
- R4: `byte_is_data` equals the level of `dc_sel` at the eighth rising edge (1 = display data, 0 = command). The level of `dc_sel` at the other seven edges has no effect.
- R5: While the link is not selected (`cs_n` high or `cs` low), edges on `sclk` shift nothing and produce no strobe.
- R6: A deselect clears the bit count and the partial byte. A byte cut short by a deselect gives no strobe, and the first byte after reselect is received aligned and intact.
- R7: Between strobes, `byte_data` and `byte_is_data` keep their values whatever happens on `sdin` and `dc_sel`.
- R8: Only rising edges of `sclk` sample `sdin`. A change of `sdin` while `sclk` is high, or at its falling edge, has no effect.
- R9: Back-to-back bytes within one select window are each framed by their own eight edges, with no deselect between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock (asynchronous) |
| sdin | input | 1 | Serial data, MSB first |
| dc_sel | input | 1 | Data (1) / command (0) select, sampled on the byte's last edge |
| byte_vld | output | 1 | One-cycle strobe: a byte is complete |
| byte_data | output | 8 | Last completed byte |
| byte_is_data | output | 1 | Tag of the last completed byte |

## Verification
Random byte values with random tags, sent in runs without deselect, check the MSB-first assembly and the byte framing. In these runs `sdin` is flipped while `sclk` is high, so a receiver that sampled on falling edges would collect the inverted bits. Some bytes toggle `dc_sel` on every edge except the last, which shows whether the tag comes from the final edge or an earlier one. Partial bytes cut off by a deselect, and clock bursts sent while either select is inactive, show whether stale bits or counts survive into the next real byte.

// File: rtl/srx_pkg.sv
package srx_pkg;
  parameter int unsigned SRX_BYTE_W = 8;
  typedef enum logic {TAG_CMD = 1'b0, TAG_DATA = 1'b1} srx_tag_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[LAST];
  end
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
  import srx_pkg::*;
#(
  parameter int unsigned BYTE_W = SRX_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sclk_s,
  input  logic              sdin_s,
  input  logic              dc_s,
  output logic              done,
  output logic [BYTE_W-1:0] word,
  output srx_tag_e          tag
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic              sclk_q;
  logic              rise;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  assign rise = sclk_s & ~sclk_q;
  assign done = sel & rise & (cnt == CNT_LAST);
  assign word = {shreg[BYTE_W-2:0], sdin_s};
  assign tag  = dc_s ? TAG_DATA : TAG_CMD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (!sel) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (rise) begin
      shreg <= word;
      cnt   <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
    end
  end

  AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt == '0) && (shreg == '0)); // R6
  AST_NO_DONE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !done); // R5
  AST_CNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rise && cnt != CNT_LAST) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R9
  AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !rise) |=> $stable(cnt) && $stable(shreg)); // R8
  AST_DONE_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cnt == '0); // R3
endmodule

// File: rtl/srx_outreg.sv
module srx_outreg
  import srx_pkg::*;
#(
  parameter int unsigned BYTE_W = SRX_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [BYTE_W-1:0] word,
  input  srx_tag_e          tag,
  output logic              vld,
  output logic [BYTE_W-1:0] data,
  output logic              is_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld     <= 1'b0;
      data    <= '0;
      is_data <= 1'b0;
    end else begin
      vld <= done;
      if (done) begin
        data    <= word;
        is_data <= (tag == TAG_DATA);
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(data) && $stable(is_data)); // R7
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
  import srx_pkg::*;
#(
  parameter int unsigned BYTE_W      = SRX_BYTE_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              dc_sel,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_is_data
);
  localparam int unsigned N_SYNC = 5;

  logic [N_SYNC-1:0] raw, synced;
  logic              sel;
  logic              done;
  logic [BYTE_W-1:0] word;
  srx_tag_e          tag;

  assign raw = {cs_n, cs, sclk, sdin, dc_sel};
  assign sel = ~synced[4] & synced[3];

  srx_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw), .q_sync(synced));

  srx_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk_s(synced[2]),
    .sdin_s(synced[1]), .dc_s(synced[0]),
    .done(done), .word(word), .tag(tag));

  srx_outreg #(.BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .done(done), .word(word), .tag(tag),
    .vld(byte_vld), .data(byte_data), .is_data(byte_is_data));

  AST_VLD_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !byte_vld); // R5
endmodule

// File: tb/tb_serial_byte_rx.sv
module tb_serial_byte_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, cs = 1'b0, sclk = 1'b0, sdin = 1'b0, dc_sel = 1'b0;
  logic       byte_vld;
  logic [7:0] byte_data;
  logic       byte_is_data;

  int errors = 0, checks = 0;
  int strobes = 0, wide = 0;
  logic vld_d = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_byte_rx dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs(cs), .sclk(sclk),
    .sdin(sdin), .dc_sel(dc_sel), .byte_vld(byte_vld),
    .byte_data(byte_data), .byte_is_data(byte_is_data));

  always @(negedge clk) begin
    if (byte_vld) strobes++;
    if (byte_vld && vld_d) wide++;
    vld_d <= byte_vld;
  end

  function automatic logic exp_bit(input logic [7:0] v, input int i);
    return v[7 - i];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic select(input bit on);
    cs_n = ~on; cs = on; wait_clk(6);
  endtask

  // nbits bits MSB first; sdin flipped while sclk high; dc_sel noise before last edge
  task automatic send_bits(input logic [7:0] v, input logic tag, input int nbits,
                           input bit noisy_dc);
    for (int i = 0; i < nbits; i++) begin
      sdin = exp_bit(v, i);
      dc_sel = (i == 7) ? tag : (noisy_dc ? ~tag : tag);
      wait_clk(3);
      sclk = 1'b1; wait_clk(3);
      sdin = ~exp_bit(v, i);
      dc_sel = ~dc_sel;
      wait_clk(1);
      sclk = 1'b0;
    end
    wait_clk(8);
  endtask

  task automatic byte_check(input string req, input logic [7:0] v, input logic tag,
                            input int s0);
    check({req, " strobe count"}, strobes - s0, 1);
    check({req, " data"}, byte_data, v);
    check({req, " tag"}, byte_is_data, tag);
  endtask

  initial begin
    wait_clk(600000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int s0;
    logic [7:0] v;
    logic t;
    void'($urandom(32'd1234));
    wait_clk(3);
    check("R1 vld", byte_vld, 0);
    check("R1 data", byte_data, 0);
    check("R1 tag", byte_is_data, 0);
    rst_n = 1'b1; wait_clk(3);

    select(1);
    s0 = strobes; send_bits(8'hA5, 1'b1, 8, 0);
    byte_check("R2 R8", 8'hA5, 1'b1, s0);
    s0 = strobes; send_bits(8'h3C, 1'b0, 8, 1);
    byte_check("R4 cmd", 8'h3C, 1'b0, s0);
    s0 = strobes; send_bits(8'h81, 1'b1, 8, 1);
    byte_check("R4 data", 8'h81, 1'b1, s0);

    // R7: noise with no clock edge
    sdin = 1'b0; dc_sel = 1'b0; wait_clk(5); sdin = 1'b1; dc_sel = 1'b1; wait_clk(5);
    check("R7 data hold", byte_data, 8'h81);
    check("R7 tag hold", byte_is_data, 1);

    // R6: partial then deselect
    s0 = strobes; send_bits(8'hFF, 1'b0, 5, 0);
    select(0); select(1);
    check("R6 no strobe partial", strobes - s0, 0);
    s0 = strobes; send_bits(8'h5A, 1'b0, 8, 0);
    byte_check("R6 realigned", 8'h5A, 1'b0, s0);

    // R5: clock while deselected by each select line
    cs_n = 1'b1; wait_clk(6);
    s0 = strobes; send_bits(8'hF0, 1'b1, 8, 0);
    check("R5 cs_n high", strobes - s0, 0);
    cs_n = 1'b0; cs = 1'b0; wait_clk(6);
    send_bits(8'h0F, 1'b1, 8, 0);
    check("R5 cs low", strobes - s0, 0);
    select(1);
    s0 = strobes; send_bits(8'hC3, 1'b1, 8, 0);
    byte_check("R5 after reselect", 8'hC3, 1'b1, s0);

    // R9 + R3: random back-to-back bytes, occasional partial+deselect
    for (int k = 0; k < 40; k++) begin
      v = 8'($urandom); t = 1'($urandom);
      if (($urandom % 5) == 0) begin
        send_bits(8'($urandom), 1'b1, 1 + ($urandom % 7), 0);
        select(0); select(1);
      end
      s0 = strobes; send_bits(v, t, 8, $urandom % 2);
      byte_check("R9 random", v, t, s0);
    end
    check("R3 single-cycle strobes", wide, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule